// File: doc/BRIEF.md
# Disk Drive Host Register Responder

This block is the device end of an 8-bit disk interface that sits on an ISA-style I/O bus. It watches the host's read and write strobes, the card select, the DMA address-enable line and the two low address bits. It runs on a fast core clock and brings every bus input into that clock domain through a two-flop synchronizer. A host write to one of the control offsets is latched and reported to the drive firmware as a one-cycle pulse. A host read of the status offset is answered on the 8-bit data lines. For that answer the block first points the external bus transceiver toward the host and then enables its data pin drivers. When the read strobe returns high it releases the pins before it turns the transceiver back.

The status byte combines the live levels of the drive's DMA request and interrupt request pins with four flag bits held inside the block. Firmware overwrites the held flags through a simple load port. A host write to the select offset raises the busy flag straight away. A host write to the reset offset is a light abort: it clears busy at once, so the drive reports ready on the very next read, and it leaves the other flags alone.

Top module: `xta_responder`

## Requirements
- R1: A status read is answered only while the read strobe, card select, address enable and A1 are all low and A0 is high (offset 1). Any other read leaves `dataOe` low for the whole access.
- R2: The status byte is bit 0 = DRQ pin, bit 1 = IRQ pin (both live, re-sampled every cycle while driving), bits 5:2 = held flags (flag 0 is busy, at byte bit 2), and bits 7:6 = 0.
- R3: On a decoded read, `xcvrToHost` goes high at least one cycle before `dataOe` rises. `dataOut` is zero whenever `dataOe` is low.
- R4: After the read strobe returns high, `dataOe` falls first and `xcvrToHost` falls on the following cycle.
- R5: A write with card select and address enable low at offset 2 (select) sets the busy flag before the next read. It pulses `selectPulse` for one cycle and latches the data byte into `selectReg`.
- R6: A write at offset 1 (reset) clears only the busy flag, keeps the other three flags, and pulses `resetPulse` for one cycle.
- R7: A write at offset 3 latches the data byte into `controlReg`. A write at offset 0, or any write with address enable high, changes no output.
- R8: Each strobe edge produces exactly one access, and back-to-back select writes each produce their own pulse.
- R9: Read data is valid on the pins within 13 clock cycles after the read strobe falls.
- R10: A cycle with `fwLoad` high replaces all held flags with `fwFlags`. A select or reset write in the same cycle still decides the busy flag.
- R11: While reset is asserted and after it is released, all outputs are low and the held flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast core clock |
| rst | input | 1 | Asynchronous active-high reset |
| iorN | input | 1 | Host I/O read strobe, active low |
| iowN | input | 1 | Host I/O write strobe, active low |
| csN | input | 1 | Card select, active low |
| aen | input | 1 | DMA address enable, high blocks I/O decode |
| addr | input | 2 | Register offset A1:A0 |
| dataIn | input | 8 | Data lines as seen from the bus |
| drqPin | input | 1 | Drive's DMA request pin level |
| irqPin | input | 1 | Drive's interrupt request pin level |
| fwLoad | input | 1 | Firmware flag load strobe, clk domain |
| fwFlags | input | 4 | Firmware flag value |
| dataOut | output | 8 | Byte driven onto the data lines |
| dataOe | output | 1 | Data pin output enable |
| xcvrToHost | output | 1 | Transceiver direction, high points to host |
| selectPulse | output | 1 | One-cycle pulse per select write |
| resetPulse | output | 1 | One-cycle pulse per reset write |
| selectReg | output | 8 | Last byte written to the select offset |
| controlReg | output | 8 | Last byte written to the control offset |

## Verification
A wrong read-state value appears at the pins within one cycle. It shows up as the pin enable high while the transceiver points away from the host, as a late or missing release, or as a skipped turnaround cycle. The bench's reference model catches each of these on the next clock comparison. A wrong held flag stays hidden until the next status read, which then returns a byte that differs in bits 5:2. For that reason each select, reset and firmware load in the bench is followed by a read. A bad synchronizer or edge detector shifts every output by a cycle, or doubles or drops a pulse. The model and the pulse counters see that within three cycles of the strobe edge.

// File: rtl/xta_pkg.sv
package xta_pkg;
  localparam int DATA_W = 8;
  localparam int FLAG_W = 4;
  localparam int BUSY_BIT = 0;

  localparam logic [1:0] OFS_STATUS = 2'd1;
  localparam logic [1:0] OFS_RESET = 2'd1;
  localparam logic [1:0] OFS_SELECT = 2'd2;
  localparam logic [1:0] OFS_CONTROL = 2'd3;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_TURN = 2'd1,
    RD_DRIVE = 2'd2,
    RD_RELEASE = 2'd3
  } rdState_t;

  typedef struct packed {
    logic driveNext;
    logic selWr;
    logic rstWr;
    logic ctlWr;
  } dpStrobes_t;
endpackage

// File: rtl/xta_sync.sv
module xta_sync #(
  parameter int W = 16,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/xta_ctrl.sv
module xta_ctrl
  import xta_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       iorS,
  input  logic       iowS,
  input  logic       csS,
  input  logic       aenS,
  input  logic [1:0] addrS,
  output dpStrobes_t strobes,
  output logic       xcvrToHost
);
  rdState_t state, nextState;
  logic iorD, iowD;
  logic rdHit, wrHit;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      iorD <= 1'b1;
      iowD <= 1'b1;
      state <= RD_IDLE;
    end else begin
      iorD <= iorS;
      iowD <= iowS;
      state <= nextState;
    end
  end

  // falling read strobe with a full status-offset decode
  assign rdHit = !iorS && iorD && !csS && !aenS && (addrS == OFS_STATUS);
  // write acts once, at the end of the strobe
  assign wrHit = iowS && !iowD && !csS && !aenS;

  always_comb begin
    nextState = state;
    unique case (state)
      RD_IDLE:    if (rdHit) nextState = RD_TURN;
      RD_TURN:    nextState = RD_DRIVE;
      RD_DRIVE:   if (iorS) nextState = RD_RELEASE;
      RD_RELEASE: nextState = rdHit ? RD_TURN : RD_IDLE;
      default:    nextState = RD_IDLE;
    endcase
  end

  always_comb begin
    strobes.driveNext = (nextState == RD_DRIVE);
    strobes.selWr = wrHit && (addrS == OFS_SELECT);
    strobes.rstWr = wrHit && (addrS == OFS_RESET);
    strobes.ctlWr = wrHit && (addrS == OFS_CONTROL);
  end

  assign xcvrToHost = (state != RD_IDLE);
endmodule

// File: rtl/xta_datapath.sv
module xta_datapath
  import xta_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  dpStrobes_t        strobes,
  input  logic [DATA_W-1:0] dataS,
  input  logic              drqS,
  input  logic              irqS,
  input  logic              fwLoad,
  input  logic [FLAG_W-1:0] fwFlags,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              selectPulse,
  output logic              resetPulse,
  output logic [DATA_W-1:0] selectReg,
  output logic [DATA_W-1:0] controlReg
);
  localparam int PAD_W = DATA_W - FLAG_W - 2;

  logic [FLAG_W-1:0] heldFlags, flagsNext;
  logic [DATA_W-1:0] statusByte;

  assign statusByte = {{PAD_W{1'b0}}, heldFlags, irqS, drqS};

  always_comb begin
    flagsNext = fwLoad ? fwFlags : heldFlags;
    if (strobes.selWr) flagsNext[BUSY_BIT] = 1'b1;
    if (strobes.rstWr) flagsNext[BUSY_BIT] = 1'b0;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      heldFlags <= '0;
      dataOut <= '0;
      dataOe <= 1'b0;
      selectPulse <= 1'b0;
      resetPulse <= 1'b0;
      selectReg <= '0;
      controlReg <= '0;
    end else begin
      heldFlags <= flagsNext;
      dataOe <= strobes.driveNext;
      dataOut <= strobes.driveNext ? statusByte : '0;
      selectPulse <= strobes.selWr;
      resetPulse <= strobes.rstWr;
      if (strobes.selWr) selectReg <= dataS;
      if (strobes.ctlWr) controlReg <= dataS;
    end
  end
endmodule

// File: rtl/xta_responder.sv
module xta_responder
  import xta_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              iorN,
  input  logic              iowN,
  input  logic              csN,
  input  logic              aen,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              drqPin,
  input  logic              irqPin,
  input  logic              fwLoad,
  input  logic [FLAG_W-1:0] fwFlags,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              xcvrToHost,
  output logic              selectPulse,
  output logic              resetPulse,
  output logic [DATA_W-1:0] selectReg,
  output logic [DATA_W-1:0] controlReg
);
  localparam int BUS_W = DATA_W + 8;
  localparam logic [BUS_W-1:0] BUS_IDLE = {4'b1111, {(BUS_W-4){1'b0}}};

  logic [BUS_W-1:0] busRaw, busS;
  dpStrobes_t strobes;

  assign busRaw = {iorN, iowN, csN, aen, addr, dataIn, drqPin, irqPin};

  xta_sync #(.W(BUS_W), .STAGES(2), .RST_VAL(BUS_IDLE)) uSync (
    .clk(clk), .rst(rst), .d(busRaw), .q(busS)
  );

  xta_ctrl uCtrl (
    .clk(clk), .rst(rst),
    .iorS(busS[BUS_W-1]), .iowS(busS[BUS_W-2]),
    .csS(busS[BUS_W-3]), .aenS(busS[BUS_W-4]),
    .addrS(busS[BUS_W-5:BUS_W-6]),
    .strobes(strobes), .xcvrToHost(xcvrToHost)
  );

  xta_datapath uDp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .dataS(busS[DATA_W+1:2]), .drqS(busS[1]), .irqS(busS[0]),
    .fwLoad(fwLoad), .fwFlags(fwFlags),
    .dataOut(dataOut), .dataOe(dataOe),
    .selectPulse(selectPulse), .resetPulse(resetPulse),
    .selectReg(selectReg), .controlReg(controlReg)
  );
endmodule

// File: rtl/xta_checker.sv
module xta_checker #(
  parameter int DATA_W = 8,
  parameter int FLAG_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input logic              xcvrToHost,
  input logic              selectPulse,
  input logic              resetPulse
);
  assert_oe_needs_dir_R3: assert property (@(posedge clk) disable iff (rst)
    dataOe |-> xcvrToHost);

  assert_dir_before_oe_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(dataOe) |-> $past(xcvrToHost));

  assert_quiet_bus_R3: assert property (@(posedge clk) disable iff (rst)
    !dataOe |-> (dataOut == '0));

  assert_oe_off_before_dir_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(xcvrToHost) |-> !$past(dataOe));

  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (rst)
    dataOe |-> (dataOut[DATA_W-1:FLAG_W+2] == '0));

  assert_one_write_kind_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({selectPulse, resetPulse}));
endmodule

bind xta_responder xta_checker #(.DATA_W(xta_pkg::DATA_W), .FLAG_W(xta_pkg::FLAG_W)) uChk (
  .clk(clk), .rst(rst), .dataOut(dataOut), .dataOe(dataOe),
  .xcvrToHost(xcvrToHost), .selectPulse(selectPulse), .resetPulse(resetPulse)
);

// File: tb/tb_xta_responder.sv
`timescale 1ns/1ps
module tb_xta_responder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iorN = 1'b1, iowN = 1'b1, csN = 1'b1, aen = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] dataIn = 8'd0;
  logic drqPin = 1'b0, irqPin = 1'b0;
  logic fwLoad = 1'b0;
  logic [3:0] fwFlags = 4'd0;
  logic [7:0] dataOut, selectReg, controlReg;
  logic dataOe, xcvrToHost, selectPulse, resetPulse;

  int checks = 0;
  int errors = 0;
  int selCount = 0;
  int rstCount = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  xta_responder dut (
    .clk(clk), .rst(rst), .iorN(iorN), .iowN(iowN), .csN(csN), .aen(aen),
    .addr(addr), .dataIn(dataIn), .drqPin(drqPin), .irqPin(irqPin),
    .fwLoad(fwLoad), .fwFlags(fwFlags), .dataOut(dataOut), .dataOe(dataOe),
    .xcvrToHost(xcvrToHost), .selectPulse(selectPulse), .resetPulse(resetPulse),
    .selectReg(selectReg), .controlReg(controlReg)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: bus pins reach the decoder after two clocks,
  // a strobe edge is one change between consecutive synchronized samples.
  logic [15:0] pin1, pin2;
  bit lastIor, lastIow;
  int mPhase;  // 0 idle, 1 turning, 2 driving, 3 releasing
  logic [3:0] mFlags;
  logic [7:0] mOut, mSel, mCtl;
  bit mOe, mSelP, mRstP;

  always @(posedge clk) begin
    int nxt;
    bit rdGo, wrGo;
    logic [7:0] stat;
    logic [3:0] f;
    if (rst) begin
      pin1 = 16'hF000; pin2 = 16'hF000; lastIor = 1; lastIow = 1;
      mPhase = 0; mFlags = 0; mOut = 0; mSel = 0; mCtl = 0;
      mOe = 0; mSelP = 0; mRstP = 0;
    end else begin
      rdGo = (mPhase == 0 || mPhase == 3) && !pin2[15] && lastIor &&
             !pin2[13] && !pin2[12] && pin2[11:10] == 2'd1;
      wrGo = pin2[14] && !lastIow && !pin2[13] && !pin2[12];
      if (mPhase == 1) nxt = 2;
      else if (mPhase == 2) nxt = pin2[15] ? 3 : 2;
      else nxt = rdGo ? 1 : 0;
      stat = {2'b00, mFlags, pin2[0], pin2[1]};
      mOe = (nxt == 2);
      mOut = mOe ? stat : 8'd0;
      mSelP = wrGo && pin2[11:10] == 2'd2;
      mRstP = wrGo && pin2[11:10] == 2'd1;
      if (mSelP) mSel = pin2[9:2];
      if (wrGo && pin2[11:10] == 2'd3) mCtl = pin2[9:2];
      f = fwLoad ? fwFlags : mFlags;
      if (mSelP) f[0] = 1'b1;
      if (mRstP) f[0] = 1'b0;
      mFlags = f;
      mPhase = nxt;
      lastIor = pin2[15]; lastIow = pin2[14];
      pin2 = pin1;
      pin1 = {iorN, iowN, csN, aen, addr, dataIn, drqPin, irqPin};
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(dataOut == mOut, "R2 status byte", dataOut, mOut);
      chk(dataOe == mOe, "R3 pin enable", dataOe, mOe);
      chk(xcvrToHost == (mPhase != 0), "R4 transceiver dir", xcvrToHost, mPhase != 0);
      chk(selectPulse == mSelP, "R5 select pulse", selectPulse, mSelP);
      chk(selectReg == mSel, "R5 select reg", selectReg, mSel);
      chk(resetPulse == mRstP, "R6 reset pulse", resetPulse, mRstP);
      chk(controlReg == mCtl, "R7 control reg", controlReg, mCtl);
      if (selectPulse) selCount++;
      if (resetPulse) rstCount++;
    end
  end

  // Host read: returns whether the pins were ever driven, the first cycle they were,
  // and the byte seen near the end of the strobe. flipAt toggles drqPin mid-read.
  task automatic hostRead(input logic [1:0] a, input bit aenV, input bit csV, input int flipAt,
                          output bit sawOe, output int firstOe, output logic [7:0] seen);
    int lowLen = 20;
    sawOe = 0; firstOe = -1; seen = 8'hxx;
    @(negedge clk); addr = a; aen = aenV; csN = csV;
    @(negedge clk); iorN = 1'b0;
    for (int i = 0; i < lowLen; i++) begin
      @(negedge clk);
      if (i == flipAt) drqPin = ~drqPin;
      if (dataOe) begin
        sawOe = 1;
        if (firstOe < 0) firstOe = i + 1;
      end
      if (i == lowLen - 2) seen = dataOut;
    end
    iorN = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (dataOe && i > 3) sawOe = 1;
    end
    csN = 1'b1; aen = 1'b1;
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d, input bit aenV);
    @(negedge clk); addr = a; dataIn = d; aen = aenV; csN = 1'b0;
    @(negedge clk); iowN = 1'b0;
    repeat (6) @(negedge clk);
    iowN = 1'b1;
    repeat (6) @(negedge clk);
    csN = 1'b1; aen = 1'b1;
  endtask

  task automatic loadFlags(input logic [3:0] f);
    @(negedge clk); fwFlags = f; fwLoad = 1'b1;
    @(negedge clk); fwLoad = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit saw;
    int first;
    logic [7:0] b;
    int sc;
    repeat (4) @(negedge clk);
    chk(dataOut == 0 && !dataOe && !xcvrToHost && !selectPulse && !resetPulse,
        "R11 outputs in reset", {dataOut, dataOe, xcvrToHost}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(selectReg == 0 && controlReg == 0, "R11 regs after reset", {selectReg, controlReg}, 0);

    drqPin = 1'b1; irqPin = 1'b0;
    hostRead(2'd1, 0, 0, -1, saw, first, b);
    chk(b == 8'h01, "R11 flags zero after reset", b, 8'h01);
    chk(saw && first >= 1 && first <= 13, "R9 read latency", first, 13);

    loadFlags(4'b1010);
    hostRead(2'd1, 0, 0, -1, saw, first, b);
    chk(b == 8'h29, "R10 firmware flags", b, 8'h29);

    hostWrite(2'd2, 8'h5A, 0);
    chk(selectReg == 8'h5A, "R5 select latch", selectReg, 8'h5A);
    hostRead(2'd1, 0, 0, -1, saw, first, b);
    chk(b == 8'h2D, "R5 busy set after select", b, 8'h2D);

    hostWrite(2'd1, 8'h00, 0);
    hostRead(2'd1, 0, 0, -1, saw, first, b);
    chk(b == 8'h29, "R6 reset clears busy only", b, 8'h29);
    chk(rstCount == 1, "R6 one reset pulse", rstCount, 1);

    hostWrite(2'd3, 8'hC3, 0);
    chk(controlReg == 8'hC3, "R7 control latch", controlReg, 8'hC3);
    sc = selCount;
    hostWrite(2'd0, 8'h11, 0);
    hostWrite(2'd2, 8'h77, 1);
    chk(controlReg == 8'hC3 && selectReg == 8'h5A && selCount == sc,
        "R7 ignored writes", {controlReg, selectReg}, 16'hC35A);
    hostRead(2'd1, 0, 0, -1, saw, first, b);
    chk(b == 8'h29, "R7 ignored write left flags", b, 8'h29);

    hostRead(2'd1, 1, 0, -1, saw, first, b);
    chk(!saw, "R1 aen high read", saw, 0);
    hostRead(2'd1, 0, 1, -1, saw, first, b);
    chk(!saw, "R1 card not selected", saw, 0);
    hostRead(2'd0, 0, 0, -1, saw, first, b);
    chk(!saw, "R1 A0 low read", saw, 0);
    hostRead(2'd3, 0, 0, -1, saw, first, b);
    chk(!saw, "R1 A1 high read", saw, 0);

    sc = selCount;
    for (int k = 0; k < 3; k++) hostWrite(2'd2, 8'h10 + 8'(k), 0);
    chk(selCount == sc + 3, "R8 repeated select writes", selCount, sc + 3);
    chk(selectReg == 8'h12, "R8 last select kept", selectReg, 8'h12);

    hostWrite(2'd1, 8'h00, 0);
    drqPin = 1'b1;
    hostRead(2'd1, 0, 0, 8, saw, first, b);
    chk(b == 8'h28, "R2 live DRQ during read", b, 8'h28);
    irqPin = 1'b1;
    hostRead(2'd1, 0, 0, -1, saw, first, b);
    chk(b == 8'h2A, "R2 live IRQ", b, 8'h2A);

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule